// File: doc/BRIEF.md
# Parallel Port Handshake Control Register

This block is the 16-bit control word of a parallel-port handshake controller. A host writes and reads it over a plain register bus: a write strobe with a data word, and a read word that always shows the present contents. The stored bits turn into direct controls for the handshake logic. There is a one-clock start pulse for the engine that polls transmit descriptors. There are override drives for the BUSY line in both directions, a forced-acknowledge drive, the transfer direction and a 7-bit mode field.

The set-BUSY and clear-BUSY commands do not fade after a fixed time. Each one stays pending until the block sees the real BUSY line reach the requested level, and then it clears itself. The register is cleared by the hard reset only. A soft reset input leaves it untouched.

Bit numbering in the brief is on the `[15:0]` vector. Bit 15 is the most significant bit.

Top module: `pp_hs_ctrl_reg`

## Requirements
- R1: While `hard_rst_n` is low, `rdata` reads 0x0000 and every control output is 0.
- R2: `soft_rst_n` has no effect: the stored contents and the outputs evolve exactly as if it were held high.
- R3: Bits 14:12 always read 0, whatever is written to them.
- R4: A write with bit 15 (start) = 1 makes bit 15 read 1 for exactly the next clock and 0 after that. When bit 0 (direction) = 1 (transmit), `start_pulse` is high during that same single clock.
- R5: When bit 0 = 0 (receive), a start write still reads back for one clock, but `start_pulse` stays low.
- R6: `ack_force` follows bit 11 (forced acknowledge), which is an ordinary read/write bit.
- R7: Bit 9 (set-BUSY) is loaded by a write. It clears itself on the first clock without a write on which `busy_line` is 1. `busy_drive_hi` = bit 9 AND bit 8 (override enable).
- R8: Bit 10 (clear-BUSY) is loaded by a write. It clears itself on the first clock without a write on which `busy_line` is 0. `busy_drive_lo` = bit 10 AND bit 8.
- R9: With bit 8 = 0, neither BUSY drive is asserted, even while bit 9 or bit 10 is pending.
- R10: A write with bits 10 and 9 both set stores only bit 10, so clear-BUSY wins.
- R11: Bit 0 and bits 7:1 store the written value and appear on `dir_tx` and `mode_cfg`. Any write reloads every writable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| hard_rst_n | input | 1 | Asynchronous hard reset, active low |
| soft_rst_n | input | 1 | Soft reset, active low; ignored by the register |
| wr_en | input | 1 | Write strobe |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Current register contents |
| busy_line | input | 1 | Observed level of the BUSY pin |
| start_pulse | output | 1 | One-clock start request to the descriptor poller |
| busy_drive_hi | output | 1 | Force BUSY high |
| busy_drive_lo | output | 1 | Force BUSY low |
| ack_force | output | 1 | Force ACK asserted |
| dir_tx | output | 1 | 1 = transmit, 0 = receive |
| mode_cfg | output | 7 | Mode and handshake-select field |

## Verification
The hardest case to reach is a pending BUSY command that stays pending. Its self-clear depends on the BUSY level seen on clocks with no write, so random traffic almost always clears it or overwrites it at once. Directed phases therefore hold `busy_line` at the opposite level for several idle clocks and toggle the soft reset during that time. Only then do they release the line. Random phases follow with mixed write density and a random `busy_line`.

// File: rtl/pp_hs_ctrl_reg.sv
module pp_hs_ctrl_reg (
  input  logic        clk,
  input  logic        hard_rst_n,
  input  logic        soft_rst_n,
  input  logic        wr_en,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  input  logic        busy_line,
  output logic        start_pulse,
  output logic        busy_drive_hi,
  output logic        busy_drive_lo,
  output logic        ack_force,
  output logic        dir_tx,
  output logic [6:0]  mode_cfg
);

  logic       str_q, sack_q, cbsy_q, sbsy_q, ebsy_q, dir_q;
  logic [6:0] mode_q;

  always_ff @(posedge clk or negedge hard_rst_n) begin
    if (!hard_rst_n) begin
      str_q  <= 1'b0;
      sack_q <= 1'b0;
      cbsy_q <= 1'b0;
      sbsy_q <= 1'b0;
      ebsy_q <= 1'b0;
      dir_q  <= 1'b0;
      mode_q <= '0;
    end else begin
      str_q <= wr_en & wdata[15];
      if (wr_en) begin
        sack_q <= wdata[11];
        cbsy_q <= wdata[10];
        sbsy_q <= wdata[9] & ~wdata[10];
        ebsy_q <= wdata[8];
        mode_q <= wdata[7:1];
        dir_q  <= wdata[0];
      end else begin
        if (busy_line)  sbsy_q <= 1'b0;
        if (!busy_line) cbsy_q <= 1'b0;
      end
    end
  end

  assign rdata         = {str_q, 3'b000, sack_q, cbsy_q, sbsy_q, ebsy_q, mode_q, dir_q};
  assign start_pulse   = str_q & dir_q;
  assign busy_drive_hi = ebsy_q & sbsy_q;
  assign busy_drive_lo = ebsy_q & cbsy_q;
  assign ack_force     = sack_q;
  assign dir_tx        = dir_q;
  assign mode_cfg      = mode_q;

endmodule

module pp_hs_ctrl_reg_chk (
  input logic        clk,
  input logic        hard_rst_n,
  input logic        soft_rst_n,
  input logic        wr_en,
  input logic [15:0] wdata,
  input logic [15:0] rdata,
  input logic        busy_line,
  input logic        start_pulse,
  input logic        busy_drive_hi,
  input logic        busy_drive_lo
);

  p_rsvd_zero_r3: assert property (@(posedge clk) disable iff (!hard_rst_n)
    rdata[14:12] == 3'b000);

  p_start_single_r4: assert property (@(posedge clk) disable iff (!hard_rst_n)
    (start_pulse && !(wr_en && wdata[15])) |=> !start_pulse);

  p_start_needs_write_r4: assert property (@(posedge clk) disable iff (!hard_rst_n)
    !(wr_en && wdata[15]) |=> !rdata[15]);

  p_sbsy_clears_r7: assert property (@(posedge clk) disable iff (!hard_rst_n)
    (rdata[9] && busy_line && !wr_en) |=> !rdata[9]);

  p_cbsy_clears_r8: assert property (@(posedge clk) disable iff (!hard_rst_n)
    (rdata[10] && !busy_line && !wr_en) |=> !rdata[10]);

  p_drive_excl_r10: assert property (@(posedge clk) disable iff (!hard_rst_n)
    !(busy_drive_hi && busy_drive_lo));

  p_soft_hold_r2: assert property (@(posedge clk) disable iff (!hard_rst_n)
    (!soft_rst_n && !wr_en) |=> $stable({rdata[11], rdata[8:0]}));

endmodule

bind pp_hs_ctrl_reg pp_hs_ctrl_reg_chk i_chk (
  .clk(clk), .hard_rst_n(hard_rst_n), .soft_rst_n(soft_rst_n),
  .wr_en(wr_en), .wdata(wdata), .rdata(rdata), .busy_line(busy_line),
  .start_pulse(start_pulse), .busy_drive_hi(busy_drive_hi),
  .busy_drive_lo(busy_drive_lo)
);

// File: tb/test_pp_hs_ctrl_reg.sv
module test_pp_hs_ctrl_reg;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        hard_rst_n = 1'b0;
  logic        soft_rst_n = 1'b1;
  logic        wr_en = 1'b0;
  logic [15:0] wdata = '0;
  logic        busy_line = 1'b0;
  logic [15:0] rdata;
  logic        start_pulse, busy_drive_hi, busy_drive_lo, ack_force, dir_tx;
  logic [6:0]  mode_cfg;

  int vectors = 0;
  int errors  = 0;
  logic [15:0] exp_q = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pp_hs_ctrl_reg i_pp_hs_ctrl_reg (
    .clk(clk), .hard_rst_n(hard_rst_n), .soft_rst_n(soft_rst_n),
    .wr_en(wr_en), .wdata(wdata), .rdata(rdata), .busy_line(busy_line),
    .start_pulse(start_pulse), .busy_drive_hi(busy_drive_hi),
    .busy_drive_lo(busy_drive_lo), .ack_force(ack_force),
    .dir_tx(dir_tx), .mode_cfg(mode_cfg)
  );

  function automatic logic [15:0] model_next(logic [15:0] cur, logic wr,
                                             logic [15:0] wd, logic busy);
    logic [15:0] n;
    n = cur;
    n[15] = 1'b0;
    if (busy)  n[9]  = 1'b0;
    if (!busy) n[10] = 1'b0;
    if (wr) begin
      n[15]  = wd[15];
      n[11]  = wd[11];
      n[10]  = wd[10];
      n[9]   = wd[9] & ~wd[10];
      n[8:0] = wd[8:0];
    end
    n[14:12] = 3'b000;
    return n;
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R3 reserved bits", {13'd0, rdata[14:12]}, 16'd0);
    chk("R11 read word", rdata, exp_q);
    chk("R4 start pulse", {15'd0, start_pulse}, {15'd0, exp_q[15] & exp_q[0]});
    chk("R7 busy drive high", {15'd0, busy_drive_hi}, {15'd0, exp_q[9] & exp_q[8]});
    chk("R8 busy drive low", {15'd0, busy_drive_lo}, {15'd0, exp_q[10] & exp_q[8]});
    chk("R6 ack force", {15'd0, ack_force}, {15'd0, exp_q[11]});
    chk("R11 direction", {15'd0, dir_tx}, {15'd0, exp_q[0]});
    chk("R11 mode field", {9'd0, mode_cfg}, {9'd0, exp_q[7:1]});
  endtask

  task automatic step(logic wr, logic [15:0] wd, logic busy, logic srst);
    wr_en = wr; wdata = wd; busy_line = busy; soft_rst_n = srst;
    exp_q = model_next(exp_q, wr, wd, busy);
    @(posedge clk);
    @(negedge clk);
    check_all();
  endtask

  task automatic do_hard_reset();
    @(negedge clk);
    hard_rst_n = 1'b0; wr_en = 1'b0;
    exp_q = '0;
    #1;
    check_all(); // R1
    @(negedge clk);
    check_all(); // R1
    hard_rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (2) @(negedge clk);
    check_all(); // R1 reset state
    hard_rst_n = 1'b1;

    // R4: transmit direction, start pulse one clock
    step(1'b1, 16'h0001, 1'b0, 1'b1);
    step(1'b1, 16'h8001, 1'b0, 1'b1);
    step(1'b0, 16'h0000, 1'b0, 1'b1);
    step(1'b0, 16'h0000, 1'b0, 1'b1);
    // R5: receive direction, no pulse
    step(1'b1, 16'h8000, 1'b0, 1'b1);
    step(1'b0, 16'h0000, 1'b0, 1'b1);
    // R3: reserved bits ignore writes
    step(1'b1, 16'h7000, 1'b0, 1'b1);
    // R7 with R2: set-BUSY held pending while BUSY low and soft reset toggles
    step(1'b1, 16'h0300, 1'b0, 1'b1);
    for (int i = 0; i < 4; i++) step(1'b0, 16'h0000, 1'b0, i[0]);
    step(1'b0, 16'h0000, 1'b1, 1'b1);
    // R8: clear-BUSY held pending while BUSY high
    step(1'b1, 16'h0500, 1'b1, 1'b1);
    for (int i = 0; i < 3; i++) step(1'b0, 16'h0000, 1'b1, 1'b0);
    step(1'b0, 16'h0000, 1'b0, 1'b1);
    // R9: override enable off, commands pending without drive
    step(1'b1, 16'h0200, 1'b0, 1'b1);
    step(1'b0, 16'h0000, 1'b0, 1'b1);
    step(1'b1, 16'h0400, 1'b1, 1'b1);
    step(1'b0, 16'h0000, 1'b1, 1'b1);
    // R10: both commands together, clear-BUSY wins
    step(1'b1, 16'h0700, 1'b1, 1'b1);
    step(1'b0, 16'h0000, 1'b1, 1'b1);
    step(1'b0, 16'h0000, 1'b0, 1'b1);
    // R6 and R11
    step(1'b1, 16'h08AB, 1'b0, 1'b1);
    step(1'b1, 16'h0054, 1'b0, 1'b1);

    for (int i = 0; i < 3000; i++) begin
      logic wr;
      logic [15:0] wd;
      wr = (i < 1500) ? (($urandom % 4) == 0) : (($urandom % 2) == 0);
      wd = 16'($urandom);
      step(wr, wd, 1'($urandom), (($urandom % 3) != 0));
      if (i == 1000) do_hard_reset();
    end

    do_hard_reset();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule